// File: doc/BRIEF.md
# Page Table Entry Outcome Checker

This block judges a single 64-bit page table entry that a hardware walker has just fetched during a three- or four-level virtual-memory walk. It decides whether the entry is unusable, whether it points to the next table level, whether it is a superpage whose frame number is not aligned to its size, or whether it is a usable leaf. For a usable leaf it also forms the physical address. Validity covers the base permission encoding and a 10-bit extension field in the top of the entry. That field holds a naturally-aligned-power-of-two (64 KiB contiguous page) flag, a two-bit memory-type field and seven reserved bits.

The walker presents the entry together with the current level, the low four virtual page number bits, the 12-bit page offset, two support flags and the machine-level memory-type enable, all qualified by a one-cycle strobe. The result code, the physical address and a done pulse are registered. They appear on the clock edge after the strobe and hold until the next strobe. Strobes may arrive on back-to-back cycles.

Top module: `pte_leaf_check`

## Requirements
- R1: Every cycle with `in_valid` high produces exactly one `done` pulse on the following cycle, and `done` is never high otherwise. `result` and `paddr` keep their values between pulses.
- R2: A synchronous reset clears `done`, `result` and `paddr` to zero.
- R3: Entry bit 0 is V, bit 1 R, bit 2 W, bit 3 X, bit 4 U, bit 6 A and bit 7 D. Bits 53:10 are the 44-bit frame number. The result is invalid (code 2) when V is 0, or when W is 1 and R is 0.
- R4: Entry bit 63 is the contiguous-page flag N, bits 62:61 are the memory type and bits 60:54 are reserved. Any reserved bit set, or a memory type of 3, gives invalid.
- R5: A leaf (any of R, W, X set) with N set is invalid when `napot_ok` is 0. A leaf with a nonzero memory type is invalid when `mtype_ok` or `mtype_en` is 0. Otherwise a nonzero memory type is accepted.
- R6: An entry with R, W and X all 0 is a pointer and gives code 1. It is invalid instead when D, A, U or N is set, or when its memory type is nonzero.
- R7: A valid leaf at a level above 0 with N set is invalid. This check takes priority over the alignment check.
- R8: A valid leaf at level L above 0 whose frame number has any bit set below bit 9·L gives misaligned (code 3). Otherwise it gives success (code 0).
- R9: A level-0 leaf with N set is invalid unless frame bits 3:0 equal 4'b1000. When they do, the output frame number is frame[43:4] followed by the virtual page number bits 3:0.
- R10: On success, `paddr` is the frame number (spliced per R9 where N applies) followed by the 12-bit page offset. For every other code, `paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe qualifying the inputs below |
| pte | input | 64 | Page table entry under examination |
| level | input | 2 | Walk level of the entry, 0 is the last level |
| vpn_lo | input | 4 | Low bits of the virtual page number |
| pg_ofs | input | 12 | Page offset of the virtual address |
| napot_ok | input | 1 | Contiguous 64 KiB pages are supported |
| mtype_ok | input | 1 | Memory types are supported |
| mtype_en | input | 1 | Machine-level memory-type enable |
| done | output | 1 | Result valid pulse |
| result | output | 2 | 0 success, 1 pointer, 2 invalid, 3 misaligned |
| paddr | output | 56 | Physical address on success, else 0 |

## Verification
The bound checker watches the strobe-to-pulse timing, the reset values, output holding between pulses, and the zeroed address on any non-success code on every cycle. It also checks that a cleared V bit or set reserved bits always yield the invalid code, and that a success keeps the page offset in the low address bits. Several behaviours can only be shown by the bench's directed entries: the priority of the contiguous-flag check over the alignment check on superpages, the exact alignment boundary per level, the frame splicing of a contiguous leaf, and the dependence on the support and enable inputs.

// File: rtl/pte_leaf_check.sv
module pte_leaf_check #(
  parameter int PPN_W    = 44,
  parameter int OFS_W    = 12,
  parameter int LVL_W    = 2,
  parameter int LVL_BITS = 9,
  parameter int NAP_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [63:0]            pte,
  input  logic [LVL_W-1:0]       level,
  input  logic [NAP_W-1:0]       vpn_lo,
  input  logic [OFS_W-1:0]       pg_ofs,
  input  logic                   napot_ok,
  input  logic                   mtype_ok,
  input  logic                   mtype_en,
  output logic                   done,
  output logic [1:0]             result,
  output logic [PPN_W+OFS_W-1:0] paddr
);
  localparam int PA_W = PPN_W + OFS_W;
  localparam logic [1:0] RES_OK  = 2'd0;
  localparam logic [1:0] RES_PTR = 2'd1;
  localparam logic [1:0] RES_INV = 2'd2;
  localparam logic [1:0] RES_MIS = 2'd3;
  localparam logic [NAP_W-1:0] NAP_TAG = NAP_W'(1) << (NAP_W - 1);

  logic v, r, w, x, u, a, d, nflag;
  logic [1:0]       mtype;
  logic [6:0]       rsvd;
  logic [PPN_W-1:0] ppn, sp_mask, ppn_out;
  logic             is_ptr, bad_base, bad_ext, bad_leaf, bad_ptr, bad;
  logic [1:0]       res_nxt;
  logic [PA_W-1:0]  pa_nxt;

  assign v     = pte[0];
  assign r     = pte[1];
  assign w     = pte[2];
  assign x     = pte[3];
  assign u     = pte[4];
  assign a     = pte[6];
  assign d     = pte[7];
  assign ppn   = pte[10 +: PPN_W];
  assign rsvd  = pte[60:54];
  assign mtype = pte[62:61];
  assign nflag = pte[63];

  assign is_ptr   = ~(r | w | x);
  assign bad_base = ~v | (w & ~r);
  assign bad_ext  = (rsvd != 7'd0) | (mtype == 2'd3);
  assign bad_leaf = ~is_ptr & ((nflag & ~napot_ok) |
                               ((mtype != 2'd0) & (~mtype_ok | ~mtype_en)));
  assign bad_ptr  = is_ptr & (d | a | u | nflag | (mtype != 2'd0));
  assign bad      = bad_base | bad_ext | bad_leaf | bad_ptr;

  assign sp_mask = (PPN_W'(1) << (32'(level) * LVL_BITS)) - PPN_W'(1);
  assign ppn_out = nflag ? {ppn[PPN_W-1:NAP_W], vpn_lo} : ppn;

  always_comb begin
    res_nxt = RES_OK;
    if (bad)                                    res_nxt = RES_INV;
    else if (is_ptr)                            res_nxt = RES_PTR;
    else if (level != '0) begin
      if (nflag)                                res_nxt = RES_INV;
      else if ((ppn & sp_mask) != '0)           res_nxt = RES_MIS;
    end else if (nflag && ppn[NAP_W-1:0] != NAP_TAG) res_nxt = RES_INV;
  end

  assign pa_nxt = (res_nxt == RES_OK) ? {ppn_out, pg_ofs} : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      result <= RES_OK;
      paddr  <= '0;
    end else begin
      done <= in_valid;
      if (in_valid) begin
        result <= res_nxt;
        paddr  <= pa_nxt;
      end
    end
  end
endmodule

// File: rtl/pte_leaf_check_sva.sv
module pte_leaf_check_sva #(
  parameter int PA_W  = 56,
  parameter int OFS_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [63:0]      pte,
  input logic [OFS_W-1:0] pg_ofs,
  input logic             done,
  input logic [1:0]       result,
  input logic [PA_W-1:0]  paddr
);
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst) in_valid |=> done); // R1
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !done); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(result) && $stable(paddr))); // R1
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!done && result == 2'd0 && paddr == '0)); // R2
  AST_V_CLEAR_INVALID: assert property (@(posedge clk) disable iff (rst) (in_valid && !pte[0]) |=> result == 2'd2); // R3
  AST_RSVD_INVALID: assert property (@(posedge clk) disable iff (rst) (in_valid && pte[60:54] != 7'd0) |=> result == 2'd2); // R4
  AST_FAIL_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst) (done && result != 2'd0) |-> paddr == '0); // R10
  AST_OFS_CARRIED: assert property (@(posedge clk) disable iff (rst) (in_valid ##1 (result == 2'd0)) |-> paddr[OFS_W-1:0] == $past(pg_ofs)); // R10
endmodule

bind pte_leaf_check pte_leaf_check_sva #(.PA_W(PPN_W + OFS_W), .OFS_W(OFS_W)) u_sva (
  .clk(clk), .rst(rst), .in_valid(in_valid), .pte(pte), .pg_ofs(pg_ofs),
  .done(done), .result(result), .paddr(paddr)
);

// File: tb/pte_leaf_check_test.sv
`timescale 1ns/1ps
module pte_leaf_check_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] pte = '0;
  logic [1:0]  level = '0;
  logic [3:0]  vpn_lo = '0;
  logic [11:0] pg_ofs = '0;
  logic        napot_ok = 1'b1, mtype_ok = 1'b1, mtype_en = 1'b1;
  logic        done;
  logic [1:0]  result;
  logic [55:0] paddr;

  int checks = 0, fails = 0;
  logic [1:0]  q_res[$];
  logic [55:0] q_pa[$];
  string       q_req[$];

  localparam logic [1:0] OK = 2'd0, PTR = 2'd1, INV = 2'd2, MIS = 2'd3;
  localparam logic [7:0] LEAF = 8'b1100_1111;
  localparam logic [7:0] PNTR = 8'b0000_0001;

  always #4 clk = ~clk;

  pte_leaf_check uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pte(pte), .level(level),
    .vpn_lo(vpn_lo), .pg_ofs(pg_ofs), .napot_ok(napot_ok), .mtype_ok(mtype_ok),
    .mtype_en(mtype_en), .done(done), .result(result), .paddr(paddr)
  );

  function automatic logic [63:0] mk(input logic n, input logic [1:0] mt,
                                     input logic [6:0] rs, input logic [43:0] ppn,
                                     input logic [7:0] fl);
    return {n, mt, rs, ppn, 2'b00, fl};
  endfunction

  task automatic drive(input logic [63:0] e, input logic [1:0] lv, input logic [3:0] vl,
                       input logic [11:0] of, input logic ns, input logic ms, input logic me,
                       input logic [1:0] xr, input logic [55:0] xp, input string req);
    q_res.push_back(xr);
    q_pa.push_back(xp);
    q_req.push_back(req);
    pte = e; level = lv; vpn_lo = vl; pg_ofs = of;
    napot_ok = ns; mtype_ok = ms; mtype_en = me;
    in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && done) begin
      checks++;
      if (q_res.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected done pulse, actual result=%0d expected no pulse", result);
      end else begin
        logic [1:0]  er;
        logic [55:0] ep;
        string       rq;
        er = q_res.pop_front();
        ep = q_pa.pop_front();
        rq = q_req.pop_front();
        if (result !== er || paddr !== ep) begin
          fails++;
          $display("FAIL %s: actual result=%0d paddr=%h expected result=%0d paddr=%h",
                   rq, result, paddr, er, ep);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual run still going expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0 || result !== 2'd0 || paddr !== '0) begin
      fails++;
      $display("FAIL R2: actual done=%b result=%0d paddr=%h expected 0 0 0", done, result, paddr);
    end
    rst = 1'b0;
    idle();

    drive(mk(0, 0, 0, 44'h123, LEAF & 8'hFE), 0, 0, 12'h001, 1, 1, 1, INV, '0, "R3 V clear");
    drive(mk(0, 0, 0, 44'h123, 8'b0000_0101), 0, 0, 12'h001, 1, 1, 1, INV, '0, "R3 W without R");
    idle();
    drive(mk(0, 0, 7'h01, 44'h123, LEAF), 0, 0, 12'h002, 1, 1, 1, INV, '0, "R4 reserved bit");
    drive(mk(0, 3, 0, 44'h123, LEAF), 0, 0, 12'h002, 1, 1, 1, INV, '0, "R4 memory type 3");
    drive(mk(1, 0, 0, 44'h128, LEAF), 0, 0, 12'h003, 0, 1, 1, INV, '0, "R5 contiguous unsupported");
    drive(mk(0, 1, 0, 44'h123, LEAF), 0, 0, 12'h003, 1, 1, 0, INV, '0, "R5 memory type disabled");
    drive(mk(0, 2, 0, 44'h123, LEAF), 0, 0, 12'h003, 1, 0, 1, INV, '0, "R5 memory type unsupported");
    drive(mk(0, 1, 0, 44'h123, LEAF), 0, 0, 12'h456, 1, 1, 1, OK, {44'h123, 12'h456}, "R5 memory type accepted");
    idle();
    drive(mk(0, 0, 0, 44'h777, PNTR), 2, 0, 12'h004, 1, 1, 1, PTR, '0, "R6 pointer");
    drive(mk(0, 0, 0, 44'h777, PNTR | 8'h40), 2, 0, 12'h004, 1, 1, 1, INV, '0, "R6 pointer with A");
    drive(mk(1, 0, 0, 44'h777, PNTR), 1, 0, 12'h004, 1, 1, 1, INV, '0, "R6 pointer with N");
    drive(mk(0, 1, 0, 44'h777, PNTR), 1, 0, 12'h004, 1, 1, 1, INV, '0, "R6 pointer with memory type");
    drive(mk(1, 0, 0, 44'h208, LEAF), 1, 0, 12'h005, 1, 1, 1, INV, '0, "R7 superpage contiguous misaligned");
    drive(mk(1, 0, 0, 44'h400, LEAF), 1, 0, 12'h005, 1, 1, 1, INV, '0, "R7 superpage contiguous aligned");
    drive(mk(0, 0, 0, 44'h201, LEAF), 1, 0, 12'h006, 1, 1, 1, MIS, '0, "R8 level 1 misaligned");
    drive(mk(0, 0, 0, 44'h200, LEAF), 1, 0, 12'h006, 1, 1, 1, OK, {44'h200, 12'h006}, "R8 level 1 aligned");
    drive(mk(0, 0, 0, 44'h20000, LEAF), 2, 0, 12'h007, 1, 1, 1, MIS, '0, "R8 level 2 bit 17");
    drive(mk(0, 0, 0, 44'h40000, LEAF), 2, 0, 12'h007, 1, 1, 1, OK, {44'h40000, 12'h007}, "R8 level 2 aligned");
    drive(mk(0, 0, 0, 44'h4000000, LEAF), 3, 0, 12'h008, 1, 1, 1, MIS, '0, "R8 level 3 bit 26");
    idle();
    drive(mk(1, 0, 0, 44'hABCD8, LEAF), 0, 4'h5, 12'h3F0, 1, 1, 1, OK, {44'hABCD5, 12'h3F0}, "R9 splice");
    drive(mk(1, 0, 0, 44'hABCD9, LEAF), 0, 4'h5, 12'h3F0, 1, 1, 1, INV, '0, "R9 wrong low nibble");
    drive(mk(1, 0, 0, 44'hABCD0, LEAF), 0, 4'hF, 12'h3F0, 1, 1, 1, INV, '0, "R9 low nibble zero");
    drive(mk(0, 0, 0, 44'hFFF_FFFF_FFFF, LEAF), 0, 4'h3, 12'hABC, 1, 1, 1, OK,
          {44'hFFF_FFFF_FFFF, 12'hABC}, "R10 full address");
    idle();
    idle();
    checks++;
    if (result !== OK || paddr !== {44'hFFF_FFFF_FFFF, 12'hABC}) begin
      fails++;
      $display("FAIL R1 hold: actual result=%0d paddr=%h expected 0 fffffffffffabc", result, paddr);
    end
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || result !== 2'd0 || paddr !== '0) begin
      fails++;
      $display("FAIL R2 mid-run reset: actual done=%b result=%0d paddr=%h expected 0 0 0", done, result, paddr);
    end
    rst = 1'b0;
    idle();
    checks++;
    if (q_res.size() != 0) begin
      fails++;
      $display("FAIL R1: actual %0d results missing expected 0", q_res.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule